// File: doc/BRIEF.md
# Serial peripheral master with memory-read sequencing

This block is a register-programmed SPI master. Software drives it over a small word-addressed register bus. Frames queue in a transmit FIFO and are clocked out MSB first on a serial clock that the block generates. Captured frames collect in a receive FIFO. Clock polarity, clock phase and an 8- or 16-bit frame are programmable. The serial clock period equals an even divider value, counted in input clock cycles.

Three transfer modes exist: full-duplex, transmit-only, and a memory-read mode. In memory-read mode the block first shifts out every queued frame, which holds the command, the address and any dummy bytes, with nothing captured. It then holds the data line high and clocks in a programmed number of frames. A burst begins only once a slave-select bit is nonzero, so software can fill the transmit FIFO first. The selected chip-select line stays low for the whole burst. Configuration is locked while the block is enabled, and disabling it flushes both FIFOs and aborts any burst.

Register map (word address): 0 control, 1 receive count, 2 enable, 3 slave select, 4 divider, 5 TX threshold, 6 interrupt mask, 7 status, 8 data port.

Top module: `spi_eeprom_master`

## Requirements
- R1: After reset the status reads 0x0002 (only the TX-empty bit), every cs_n_o line is high, sclk_o is low and the interrupt mask reads 0.
- R2: The divider register ignores bit 0, and a value of 0 acts as 2. While a burst is active, consecutive leading edges of sclk_o lie exactly the stored divider value of input cycles apart.
- R3: In full-duplex mode (control[1:0]=0) each frame is sent MSB first, and the frame captured from miso_i is pushed into the RX FIFO. With miso_i looped to mosi_o, the data port returns the transmitted frames in order.
- R4: In transmit-only mode (control[1:0]=1) received bits are dropped and the RX FIFO stays empty. Status bit 2 stays 0.
- R5: In memory-read mode (control[1:0]=2) the TX frames are shifted out without capture. The block then clocks exactly receive-count+1 frames with mosi_o held high, and pushes only those frames.
- R6: No serial activity occurs while the slave-select register is zero. A burst starts when a bit is nonzero and the TX FIFO holds data. Only the latched selected cs_n_o line goes low, exactly once per burst.
- R7: Status bit 0 (busy) is set from the start of shifting until the last frame ends and chip select is released.
- R8: Writes to control, divider and receive count are ignored while enable bit 0 is set. Clearing enable empties both FIFOs, clears the overflow bit and stops an active burst at once.
- R9: The TX threshold register stores values below the FIFO depth. A larger write stores depth-1.
- R10: The idle level of sclk_o equals control bit 2 (polarity). Control bit 3 (phase) selects sampling on the leading edge (0) or the trailing edge (1), and loopback works in every polarity and phase combination.
- R11: Control bit 4 selects a 16-bit frame (1) or an 8-bit frame (0). An 8-bit frame produces 8 sclk leading edges, and its RX value is zero-extended.
- R12: Writing the data port pushes the TX FIFO and reading it pops the RX FIFO. A write to a full TX FIFO is dropped and sets the sticky status bit 3.
- R13: The interrupt mask register is 8 bits wide, resets to 0 (everything masked) and reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 4 | Register word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid the cycle after a read |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | NUM_CS | Chip selects, active low |

## Verification
The bench builds the block with a FIFO depth of 4 and two chip selects. The shallow FIFO lets a fifth queued write reach the overflow path quickly, and it lets a short memory-read burst come close to filling the RX side. With two select lines the bench can confirm that the unselected line never falls. Random bursts vary polarity, phase, frame width, divider and frame count, using a loopback from mosi_o to miso_i.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;
  typedef enum logic [1:0] {
    MODE_DUPLEX = 2'd0,
    MODE_TXONLY = 2'd1,
    MODE_MEMRD  = 2'd2,
    MODE_RSVD   = 2'd3
  } xfer_mode_e;

  typedef struct packed {
    logic       wide;
    logic       cpha;
    logic       cpol;
    xfer_mode_e mode;
  } spi_cfg_t;

  localparam int unsigned DATA_W = 16;
endpackage

// File: rtl/spi_sync_fifo.sv
module spi_sync_fifo #(
  parameter int unsigned WIDTH = 16,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] rdata_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [CW-1:0]    cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign rdata_o = mem_q[rd_q];

  function automatic logic [AW-1:0] nxt(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push && !clr_i) mem_q[wr_q] <= wdata_i;
  end

  p_cnt_bound_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(DEPTH));
  p_clr_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> empty_o);
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eeprom_pkg::*;
#(
  parameter int unsigned NUM_CS = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  spi_cfg_t          cfg_i,
  input  logic [14:0]       half_i,
  input  logic [15:0]       rx_frames_i,
  input  logic [NUM_CS-1:0] ss_i,
  input  logic              tx_empty_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  output logic              rx_push_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              busy_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_n_o
);
  logic              busy_q, rxph_q, h_q, push_q;
  logic [14:0]       clk_cnt_q;
  logic [3:0]        bit_q;
  logic [15:0]       tsh_q, rsh_q, left_q;
  logic [NUM_CS-1:0] ss_q;
  logic              start, tick, bit_end, frame_end, sample, more_tx;
  logic [15:0]       tx_load;

  assign start     = en_i && !busy_q && (ss_i != '0) && !tx_empty_i;
  assign tick      = busy_q && (clk_cnt_q == half_i - 15'd1);
  assign bit_end   = tick && h_q;
  assign frame_end = bit_end && (bit_q == (cfg_i.wide ? 4'd15 : 4'd7));
  assign sample    = tick && (h_q == cfg_i.cpha);
  assign more_tx   = frame_end && !rxph_q && !tx_empty_i;
  assign tx_load   = cfg_i.wide ? tx_data_i : {tx_data_i[7:0], 8'h00};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0; rxph_q <= 1'b0; h_q <= 1'b0; push_q <= 1'b0;
      clk_cnt_q <= '0; bit_q <= '0; tsh_q <= '1; rsh_q <= '0;
      left_q <= '0; ss_q <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0; rxph_q <= 1'b0; h_q <= 1'b0; push_q <= 1'b0;
      clk_cnt_q <= '0; bit_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1; rxph_q <= 1'b0; h_q <= 1'b0; push_q <= 1'b0;
      clk_cnt_q <= '0; bit_q <= '0; tsh_q <= tx_load; ss_q <= ss_i;
    end else begin
      push_q <= frame_end && (cfg_i.mode != MODE_TXONLY) &&
                ((cfg_i.mode != MODE_MEMRD) || rxph_q);
      if (busy_q) begin
        clk_cnt_q <= tick ? '0 : clk_cnt_q + 15'd1;
        if (tick)   h_q   <= ~h_q;
        if (sample) rsh_q <= {rsh_q[14:0], miso_i};
        if (bit_end) begin
          tsh_q <= {tsh_q[14:0], 1'b1};
          bit_q <= bit_q + 4'd1;
        end
        if (frame_end) begin
          bit_q <= '0;
          if (more_tx) begin
            tsh_q <= tx_load;
          end else if (cfg_i.mode == MODE_MEMRD && !rxph_q) begin
            rxph_q <= 1'b1;
            left_q <= rx_frames_i;
            tsh_q  <= '1;
          end else if (rxph_q && left_q != '0) begin
            left_q <= left_q - 16'd1;
            tsh_q  <= '1;
          end else begin
            busy_q <= 1'b0;
          end
        end
      end
    end
  end

  assign tx_pop_o  = start || more_tx;
  assign rx_push_o = push_q;
  assign rx_data_o = cfg_i.wide ? rsh_q : {8'h00, rsh_q[7:0]};
  assign busy_o    = busy_q;
  assign sclk_o    = cfg_i.cpol ^ (busy_q & (h_q ^ cfg_i.cpha));
  assign mosi_o    = busy_q ? tsh_q[15] : 1'b1;
  assign cs_n_o    = ~(ss_q & {NUM_CS{busy_q}});

  p_cs_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && $past(busy_q) |-> $stable(cs_n_o));
  p_start_ss_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(ss_i != '0));
  p_txonly_drop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_push_o |-> cfg_i.mode != MODE_TXONLY);
  p_memrd_high_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && rxph_q |-> mosi_o);
endmodule

// File: rtl/spi_eeprom_master.sv
module spi_eeprom_master
  import spi_eeprom_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned NUM_CS = 4,
  localparam int unsigned TW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_n_o
);
  localparam logic [3:0] A_CTRL = 4'd0, A_RXCNT = 4'd1, A_EN = 4'd2, A_SS = 4'd3,
                         A_DIV = 4'd4, A_THR = 4'd5, A_MASK = 4'd6, A_STAT = 4'd7,
                         A_DATA = 4'd8;

  spi_cfg_t          cfg_q;
  logic [15:0]       rxcnt_q, div_q, rdata_q;
  logic              en_q, ovf_q;
  logic [NUM_CS-1:0] ss_q;
  logic [TW-1:0]     thr_q;
  logic [7:0]        mask_q;
  logic              wr, rd, tx_push, tx_full, tx_empty, tx_pop;
  logic              rx_push, rx_pop, rx_empty, rx_full, busy;
  logic [15:0]       tx_head, rx_head, rx_word;
  logic [14:0]       half;

  assign wr      = req_i && we_i;
  assign rd      = req_i && !we_i;
  assign tx_push = wr && (addr_i == A_DATA) && en_q;
  assign rx_pop  = rd && (addr_i == A_DATA);
  assign half    = (div_q[15:1] == '0) ? 15'd1 : div_q[15:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0; rxcnt_q <= '0; div_q <= 16'd2; en_q <= 1'b0;
      ss_q <= '0; thr_q <= '0; mask_q <= '0; ovf_q <= 1'b0;
    end else begin
      if (wr) begin
        unique case (addr_i)
          A_CTRL:  if (!en_q) cfg_q <= spi_cfg_t'(wdata_i[4:0]);
          A_RXCNT: if (!en_q) rxcnt_q <= wdata_i;
          A_EN:    en_q <= wdata_i[0];
          A_SS:    ss_q <= wdata_i[NUM_CS-1:0];
          A_DIV:   if (!en_q) div_q <= {wdata_i[15:1], 1'b0};
          A_THR:   thr_q <= (wdata_i >= 16'(DEPTH)) ? TW'(DEPTH - 1) : wdata_i[TW-1:0];
          A_MASK:  mask_q <= wdata_i[7:0];
          default: ;
        endcase
      end
      if (!en_q)                  ovf_q <= 1'b0;
      else if (tx_push && tx_full) ovf_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else if (rd) begin
      unique case (addr_i)
        A_CTRL:  rdata_q <= 16'(cfg_q);
        A_RXCNT: rdata_q <= rxcnt_q;
        A_EN:    rdata_q <= 16'(en_q);
        A_SS:    rdata_q <= 16'(ss_q);
        A_DIV:   rdata_q <= div_q;
        A_THR:   rdata_q <= 16'(thr_q);
        A_MASK:  rdata_q <= 16'(mask_q);
        A_STAT:  rdata_q <= {12'h000, ovf_q, !rx_empty, tx_empty, busy};
        A_DATA:  rdata_q <= rx_empty ? 16'h0000 : rx_head;
        default: rdata_q <= '0;
      endcase
    end
  end
  assign rdata_o = rdata_q;

  spi_sync_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk_i, .rst_ni, .clr_i(!en_q), .push_i(tx_push), .wdata_i(wdata_i),
    .pop_i(tx_pop), .rdata_o(tx_head), .full_o(tx_full), .empty_o(tx_empty));

  spi_sync_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk_i, .rst_ni, .clr_i(!en_q), .push_i(rx_push), .wdata_i(rx_word),
    .pop_i(rx_pop), .rdata_o(rx_head), .full_o(rx_full), .empty_o(rx_empty));

  spi_shift_engine #(.NUM_CS(NUM_CS)) u_engine (
    .clk_i, .rst_ni, .en_i(en_q), .cfg_i(cfg_q), .half_i(half),
    .rx_frames_i(rxcnt_q), .ss_i(ss_q), .tx_empty_i(tx_empty),
    .tx_data_i(tx_head), .tx_pop_o(tx_pop), .rx_push_o(rx_push),
    .rx_data_o(rx_word), .busy_o(busy), .sclk_o, .mosi_o, .miso_i, .cs_n_o);

  p_cfg_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_q && $past(en_q) |-> $stable(cfg_q) && $stable(div_q));
  p_thr_range_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(thr_q) < DEPTH);
  p_idle_level_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_n_o) |-> sclk_o == cfg_q.cpol);
  p_no_overflow_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_push && tx_full |=> ovf_q);
endmodule

// File: tb/spi_eeprom_master_tb_top.sv
`timescale 1ns/1ps
module spi_eeprom_master_tb_top;
  localparam int DEPTH = 4;
  localparam int NCS   = 2;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic req_i = 1'b0, we_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [15:0] wdata_i = '0, rdata_o;
  logic sclk_o, mosi_o, miso_i;
  logic [NCS-1:0] cs_n_o;

  always #10 clk_i = ~clk_i;
  assign miso_i = mosi_o;

  spi_eeprom_master #(.DEPTH(DEPTH), .NUM_CS(NCS)) dut_i (.*);

  int errors = 0, checks = 0;
  int cyc = 0, edges = 0, last_edge = -1, per_min = 0, per_max = 0;
  int falls [NCS];
  logic exp_cpol = 1'b0;
  logic sclk_prev = 1'b0;
  logic [NCS-1:0] cs_prev = '1;
  logic [15:0] txd [8];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    cyc++;
    if (cs_n_o != '1 && sclk_o != sclk_prev && sclk_o != exp_cpol) begin
      edges++;
      if (last_edge >= 0) begin
        if (per_min == 0 || cyc - last_edge < per_min) per_min = cyc - last_edge;
        if (cyc - last_edge > per_max) per_max = cyc - last_edge;
      end
      last_edge = cyc;
    end
    for (int i = 0; i < NCS; i++) if (cs_prev[i] && !cs_n_o[i]) falls[i]++;
    sclk_prev = sclk_o;
    cs_prev = cs_n_o;
  end

  task automatic mon_clear();
    edges = 0; last_edge = -1; per_min = 0; per_max = 0;
    for (int i = 0; i < NCS; i++) falls[i] = 0;
  endtask

  task automatic wr(logic [3:0] a, logic [15:0] d);
    @(negedge clk_i); req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i); req_i = 0; we_i = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    @(negedge clk_i); req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i); req_i = 0; d = rdata_o;
  endtask

  task automatic wait_idle();
    logic [15:0] s;
    repeat (4) @(negedge clk_i);
    for (int k = 0; k < 5000; k++) begin
      rd(4'd7, s);
      if (!s[0]) return;
    end
    chk("R7 busy never cleared", 1, 0);
  endtask

  function automatic int eff_div(int d);
    int e = d & 16'hfffe;
    return (e == 0) ? 2 : e;
  endfunction

  function automatic logic [15:0] exp_word(logic wide, logic [15:0] d);
    return wide ? d : {8'h00, d[7:0]};
  endfunction

  // configure (while disabled) and enable
  task automatic setup(int mode, logic cpol, logic cpha, logic wide, int div, int rxc);
    wr(4'd2, 0);
    wr(4'd0, 16'(mode | (cpol << 2) | (cpha << 3) | (wide << 4)));
    wr(4'd4, 16'(div));
    wr(4'd1, 16'(rxc));
    exp_cpol = cpol;
    wr(4'd3, 0);
    wr(4'd2, 1);
  endtask

  task automatic duplex_burst(logic cpol, logic cpha, logic wide, int div, int n, int sel);
    logic [15:0] r;
    setup(0, cpol, cpha, wide, div, 0);
    for (int i = 0; i < n; i++) begin
      txd[i] = 16'($urandom);
      wr(4'd8, txd[i]);
    end
    mon_clear();
    repeat (10) @(negedge clk_i);
    chk("R6 no edges before select", edges, 0);
    chk("R6 cs idle before select", int'(cs_n_o), 3);
    wr(4'd3, 16'(1 << sel));
    wait_idle();
    chk("R11 leading edge count", edges, n * (wide ? 16 : 8));
    chk("R2 min sclk period", per_min, eff_div(div));
    chk("R2 max sclk period", per_max, eff_div(div));
    chk("R6 selected cs falls once", falls[sel], 1);
    chk("R6 other cs untouched", falls[1 - sel], 0);
    chk("R10 idle level after burst", int'(sclk_o), int'(cpol));
    for (int i = 0; i < n; i++) begin
      rd(4'd8, r);
      chk("R3 loopback frame", r, exp_word(wide, txd[i]));
    end
    rd(4'd7, r);
    chk("R12 rx drained", r & 16'h4, 0);
  endtask

  logic [15:0] v;

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < NCS; i++) falls[i] = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    rd(4'd7, v); chk("R1 status after reset", v, 16'h0002);
    chk("R1 cs after reset", int'(cs_n_o), 3);
    chk("R1 sclk after reset", int'(sclk_o), 0);
    rd(4'd6, v); chk("R13 mask resets to zero", v, 0);
    wr(4'd6, 16'h5a); rd(4'd6, v); chk("R13 mask readback", v, 16'h5a);
    wr(4'd5, 2);  rd(4'd5, v); chk("R9 threshold in range", v, 2);
    wr(4'd5, 9);  rd(4'd5, v); chk("R9 threshold clamped", v, DEPTH - 1);

    // R8 config locked while enabled
    setup(0, 0, 0, 0, 4, 0);
    wr(4'd0, 16'h001d); rd(4'd0, v); chk("R8 ctrl locked", v, 0);
    wr(4'd4, 16'd12);   rd(4'd4, v); chk("R8 div locked", v, 4);

    // directed corners: odd divider, zero divider, both phases and widths
    duplex_burst(0, 0, 0, 5, 2, 0);
    duplex_burst(1, 1, 1, 0, 3, 1);
    duplex_burst(1, 0, 0, 2, 4, 0);
    duplex_burst(0, 1, 1, 6, 1, 1);
    for (int it = 0; it < 8; it++)
      duplex_burst(1'($urandom), 1'($urandom), 1'($urandom),
                   int'($urandom_range(0, 9)), int'($urandom_range(1, DEPTH)),
                   int'($urandom_range(0, 1)));

    // R4 transmit-only
    setup(1, 0, 1, 0, 4, 0);
    for (int i = 0; i < 3; i++) wr(4'd8, 16'(i + 3));
    mon_clear();
    wr(4'd3, 1);
    wait_idle();
    chk("R4 edges in tx-only", edges, 24);
    rd(4'd7, v); chk("R4 rx fifo empty after tx-only", v & 16'h4, 0);

    // R5 memory read: 2 tx frames then rxcnt+1 = 3 frames of ones
    setup(2, 1, 0, 0, 4, 2);
    wr(4'd8, 16'h03); wr(4'd8, 16'h40);
    mon_clear();
    wr(4'd3, 2);
    wait_idle();
    chk("R5 total edges", edges, 5 * 8);
    chk("R7 cs released at end", int'(cs_n_o), 3);
    for (int i = 0; i < 3; i++) begin
      rd(4'd8, v); chk("R5 rx frame all ones", v, 16'h00ff);
    end
    rd(4'd7, v); chk("R5 exactly rxcnt+1 frames", v & 16'h4, 0);

    // R12 overflow then drain
    setup(0, 0, 0, 1, 2, 0);
    for (int i = 0; i < DEPTH + 1; i++) begin
      txd[i] = 16'($urandom);
      wr(4'd8, txd[i]);
    end
    rd(4'd7, v); chk("R12 overflow sticky set", v & 16'h8, 16'h8);
    wr(4'd3, 1);
    wait_idle();
    for (int i = 0; i < DEPTH; i++) begin
      rd(4'd8, v); chk("R12 frames kept before overflow", v, txd[i]);
    end
    rd(4'd7, v); chk("R12 overflow stays set", v & 16'h8, 16'h8);
    wr(4'd2, 0);
    rd(4'd7, v); chk("R8 disable clears overflow", v, 16'h0002);

    // R8 abort
    setup(0, 0, 0, 1, 16, 0);
    for (int i = 0; i < DEPTH; i++) wr(4'd8, 16'h1234);
    wr(4'd3, 1);
    repeat (30) @(negedge clk_i);
    rd(4'd7, v); chk("R7 busy during burst", v & 16'h1, 1);
    chk("R6 cs low during burst", int'(cs_n_o), 2);
    wr(4'd2, 0);
    @(negedge clk_i);
    chk("R8 abort releases cs", int'(cs_n_o), 3);
    rd(4'd7, v); chk("R8 abort flushes state", v, 16'h0002);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule